// File: doc/BRIEF.md
# DMA Channel Address-Mode Sequencer

This block is one DMA channel. It moves a number of data units between two endpoints. Each endpoint is one of five classes: an external device served through an acknowledge strobe, external memory, a memory-mapped external device, an on-chip peripheral, or on-chip memory. When a start pulse arrives, a fixed legality table classifies the source/destination pair in the same cycle. The result is a one-cycle-per-unit single address transfer, a read-then-write dual address transfer, or a rejection. A rejection raises an error flag and issues no bus activity.

In single address operation, the acknowledge line goes to the device and the memory address goes to the bus in the same cycle. The data passes straight between device and memory, and the channel never holds it. In dual address operation, the channel reads the source into a holding register and writes that value to the destination. Source and destination pointers step independently: they stay fixed, increment or decrement by the unit size. The channel either holds the bus for the whole count (burst) or gives the bus up for one cycle after every unit (cycle-steal).

Top module: `dma_seq_chan`

## Requirements
- R1: Endpoint codes are: 0 acknowledged device, 1 external memory, 2 memory-mapped external device, 3 on-chip peripheral, 4 on-chip memory. Codes 5 to 7 are rejected. A pair with code 0 on one side is run as single address when the other side is code 1 or 2. Every other pair involving code 0 is rejected, including 0 to 0.
- R2: A pair drawn from codes 1 to 4 runs as dual address. If either side is code 3, `xfer_size` must equal `periph_size`; otherwise the pair is rejected.
- R3: A rejected start, or a start with `unit_count` of 0, sets `err` on the next cycle, leaves `busy` low and issues no strobe. A legal start clears `err`.
- R4: A single address unit is one bus cycle with `dack` high and the memory-side address on `bus_addr`. `bus_rd` is high when memory is the source, and `bus_wr` is high when memory is the destination.
- R5: A dual address unit reads at the source pointer, then writes at the destination pointer. `bus_wdata` equals the data returned by that read, and `dack` stays low.
- R6: Pointer modes are 0 fixed, 1 increment and 2 decrement. The step is 1, 2 or 4 bytes for `xfer_size` 0, 1 and 2. Unit n uses base plus or minus n times the step.
- R7: A strobe, its address and `dack` stay unchanged until `bus_ready` is seen high at a clock edge.
- R8: After `unit_count` units, `done` pulses for one cycle and `busy` and `bus_req` fall in that same cycle.
- R9: With `burst` low, `bus_req` drops for exactly one cycle between units. With `burst` high, it stays high from the first strobe to the last.
- R10: The first strobe appears in the cycle after the accepted start, with `bus_req` high.
- R11: `bus_rd` and `bus_wr` are never high together, and `dack` is high only with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, samples the configuration |
| src_ep | input | 3 | Source endpoint class |
| dst_ep | input | 3 | Destination endpoint class |
| xfer_size | input | 2 | Unit size: 0 byte, 1 half, 2 word |
| periph_size | input | 2 | Size the peripheral endpoint accepts |
| src_mode | input | 2 | Source pointer mode |
| dst_mode | input | 2 | Destination pointer mode |
| burst | input | 1 | 1 burst, 0 cycle-steal |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| unit_count | input | CW | Number of units |
| busy | output | 1 | Channel enabled |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected |
| bus_req | output | 1 | Bus held by the channel |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Ends the current bus cycle |
| dack | output | 1 | Acknowledge to the external device |

## Verification
A corrupted pointer shows up as a wrong `bus_addr` on the very next strobe. A wrong pair classification shows up one cycle after start: a strobe kind or `dack` level that differs from the table, or an `err` that should not be there. A lost or doubled count step shows up only at the end of the run, as a bus-cycle total and `done` timing that are off by one unit. A stuck state machine shows up in cycle-steal runs as a wrong number of released-bus cycles.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam logic [2:0] EP_ACKDEV = 3'd0;
  localparam logic [2:0] EP_XMEM   = 3'd1;
  localparam logic [2:0] EP_XMAP   = 3'd2;
  localparam logic [2:0] EP_PERIPH = 3'd3;
  localparam logic [2:0] EP_ONCHIP = 3'd4;

  localparam logic [1:0] AM_FIXED = 2'd0;
  localparam logic [1:0] AM_INC   = 2'd1;
  localparam logic [1:0] AM_DEC   = 2'd2;

  typedef enum logic [1:0] {XK_REJECT, XK_SINGLE, XK_DUAL} xkind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_WRITE, ST_GAP} st_e;
endpackage

// File: rtl/dma_pair_check.sv
module dma_pair_check
  import dma_seq_pkg::*;
(
  input  logic [2:0] src_ep,
  input  logic [2:0] dst_ep,
  input  logic [1:0] size,
  input  logic [1:0] periph_size,
  output xkind_e     kind,
  output logic       mem_is_src
);
  logic valid, src_ext, dst_ext, has_periph;

  always_comb begin
    valid      = (src_ep <= EP_ONCHIP) && (dst_ep <= EP_ONCHIP);
    src_ext    = (src_ep == EP_XMEM) || (src_ep == EP_XMAP);
    dst_ext    = (dst_ep == EP_XMEM) || (dst_ep == EP_XMAP);
    has_periph = (src_ep == EP_PERIPH) || (dst_ep == EP_PERIPH);
    kind       = XK_REJECT;
    mem_is_src = 1'b0;
    if (!valid) begin
      kind = XK_REJECT;
    end else if (src_ep == EP_ACKDEV) begin
      if (dst_ext) kind = XK_SINGLE;
    end else if (dst_ep == EP_ACKDEV) begin
      if (src_ext) begin
        kind       = XK_SINGLE;
        mem_is_src = 1'b1;
      end
    end else if (has_periph && (size != periph_size)) begin
      kind = XK_REJECT;
    end else begin
      kind = XK_DUAL;
    end
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  always_comb begin
    step = '0;
    case (size)
      2'd0:    step[0] = 1'b1;
      2'd1:    step[1] = 1'b1;
      default: step[2] = 1'b1;
    endcase
    case (mode)
      AM_INC:  nxt = cur + step;
      AM_DEC:  nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    src_ep,
  input  logic [2:0]    dst_ep,
  input  logic [1:0]    xfer_size,
  input  logic [1:0]    periph_size,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic          burst,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] unit_count,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          dack
);
  localparam int NPTR = 2;
  localparam logic [CW-1:0] LAST_UNIT = CW'(1);

  xkind_e kind_in;
  logic   mis_in, in_single;

  dma_pair_check u_pair (
    .src_ep      (src_ep),
    .dst_ep      (dst_ep),
    .size        (xfer_size),
    .periph_size (periph_size),
    .kind        (kind_in),
    .mem_is_src  (mis_in)
  );

  logic [AW-1:0] ptr_q  [NPTR];
  logic [AW-1:0] ptr_nx [NPTR];
  logic [1:0]    mode_q [NPTR];
  logic [1:0]    size_q;

  // one stepping unit per pointer (0 = source, 1 = destination)
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_step #(.AW(AW)) u_step (
      .cur  (ptr_q[g]),
      .mode (mode_q[g]),
      .size (size_q),
      .nxt  (ptr_nx[g])
    );
  end

  st_e           st_q;
  logic          burst_q, single_q, mis_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] lead_addr_c, lead_addr_n;
  logic          lead_rd, lead_wr, unit_end;

  always_comb begin
    in_single   = (kind_in == XK_SINGLE);
    lead_rd     = !single_q || mis_q;
    lead_wr     = single_q && !mis_q;
    lead_addr_c = lead_wr ? ptr_q[1]  : ptr_q[0];
    lead_addr_n = lead_wr ? ptr_nx[1] : ptr_nx[0];
    unit_end    = bus_ready &&
                  (((st_q == ST_LEAD) && single_q) || (st_q == ST_WRITE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      dack      <= 1'b0;
      burst_q   <= 1'b0;
      single_q  <= 1'b0;
      mis_q     <= 1'b0;
      size_q    <= '0;
      cnt_q     <= '0;
      for (int i = 0; i < NPTR; i++) begin
        ptr_q[i]  <= '0;
        mode_q[i] <= AM_FIXED;
      end
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (kind_in == XK_REJECT || unit_count == '0) begin
              err <= 1'b1;
            end else begin
              err       <= 1'b0;
              busy      <= 1'b1;
              bus_req   <= 1'b1;
              ptr_q[0]  <= src_addr;
              ptr_q[1]  <= dst_addr;
              mode_q[0] <= src_mode;
              mode_q[1] <= dst_mode;
              size_q    <= xfer_size;
              burst_q   <= burst;
              single_q  <= in_single;
              mis_q     <= mis_in;
              cnt_q     <= unit_count;
              dack      <= in_single;
              bus_rd    <= !in_single || mis_in;
              bus_wr    <= in_single && !mis_in;
              bus_addr  <= (in_single && !mis_in) ? dst_addr : src_addr;
              st_q      <= ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (bus_ready && !single_q) begin
            bus_wdata <= bus_rdata;
            bus_rd    <= 1'b0;
            bus_wr    <= 1'b1;
            bus_addr  <= ptr_q[1];
            st_q      <= ST_WRITE;
          end
        end
        ST_GAP: begin
          bus_req  <= 1'b1;
          dack     <= single_q;
          bus_rd   <= lead_rd;
          bus_wr   <= lead_wr;
          bus_addr <= lead_addr_c;
          st_q     <= ST_LEAD;
        end
        default: ;
      endcase

      if (unit_end) begin
        ptr_q[0] <= ptr_nx[0];
        ptr_q[1] <= ptr_nx[1];
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == LAST_UNIT) begin
          done    <= 1'b1;
          busy    <= 1'b0;
          bus_req <= 1'b0;
          bus_rd  <= 1'b0;
          bus_wr  <= 1'b0;
          dack    <= 1'b0;
          st_q    <= ST_IDLE;
        end else if (burst_q) begin
          dack     <= single_q;
          bus_rd   <= lead_rd;
          bus_wr   <= lead_wr;
          bus_addr <= lead_addr_n;
          st_q     <= ST_LEAD;
        end else begin
          bus_req <= 1'b0;
          bus_rd  <= 1'b0;
          bus_wr  <= 1'b0;
          dack    <= 1'b0;
          st_q    <= ST_GAP;
        end
      end
    end
  end
endmodule

// File: rtl/dma_seq_chan_chk.sv
module dma_seq_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_ready,
  input logic          dack
);
  // R11
  excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R11
  dack_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dack |-> (bus_rd || bus_wr));

  // R7
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_ready) |=>
      ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(dack)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_req));

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !busy) |-> !(bus_rd || bus_wr));

  // R10
  req_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_req);

  // R5
  dual_wdata_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dack && bus_ready) |=> (bus_wr && (bus_wdata == $past(bus_rdata))));

  // R9
  one_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_req) |=> bus_req);
endmodule

bind dma_seq_chan dma_seq_chan_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .bus_req   (bus_req),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ready (bus_ready),
  .dack      (dack)
);

// File: tb/test_dma_seq_chan.sv
module test_dma_seq_chan;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [2:0]    src_ep, dst_ep;
  logic [1:0]    xfer_size, periph_size, src_mode, dst_mode;
  logic          burst;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] unit_count;
  logic          busy, done, err, bus_req, bus_rd, bus_wr, dack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] rdata_of(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5a5a_0000;
  endfunction

  assign bus_rdata = rdata_of(bus_addr);

  dma_seq_chan #(.AW(AW), .DW(DW), .CW(CW)) i_dma_seq_chan (
    .clk(clk), .rst(rst), .start(start), .src_ep(src_ep), .dst_ep(dst_ep),
    .xfer_size(xfer_size), .periph_size(periph_size), .src_mode(src_mode),
    .dst_mode(dst_mode), .burst(burst), .src_addr(src_addr), .dst_addr(dst_addr),
    .unit_count(unit_count), .busy(busy), .done(done), .err(err),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .dack(dack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 reject, 1 single, 2 dual (R1, R2)
  function automatic int exp_kind(input logic [2:0] s, d, input logic [1:0] sz, psz);
    bit s_x, d_x;
    if (s > 4 || d > 4) return 0;
    s_x = (s == 1) || (s == 2);
    d_x = (d == 1) || (d == 2);
    if (s == 0) return d_x ? 1 : 0;
    if (d == 0) return s_x ? 1 : 0;
    if ((s == 3 || d == 3) && sz != psz) return 0;
    return 2;
  endfunction

  // R6
  function automatic logic [AW-1:0] addr_at(input logic [AW-1:0] base,
      input logic [1:0] m, input logic [1:0] sz, input int u);
    logic [AW-1:0] st;
    st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (m == 1) return base + st * u;
    if (m == 2) return base - st * u;
    return base;
  endfunction

  task automatic run_xfer(input logic [2:0] se, de, input logic [1:0] sz, psz, sm, dm,
      input bit bst, input logic [AW-1:0] sa, da, input logic [CW-1:0] n, input int wait_pct);
    int kind, k, mism, dn, gaps, total, u, iter;
    bit rd_e, wr_e, dk_e, rdy, first;
    logic [AW-1:0] a_e;
    logic [DW-1:0] w_e;
    string ftxt;
    kind = exp_kind(se, de, sz, psz);
    @(negedge clk);
    src_ep = se; dst_ep = de; xfer_size = sz; periph_size = psz;
    src_mode = sm; dst_mode = dm; burst = bst; src_addr = sa; dst_addr = da;
    unit_count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (kind == 0 || n == 0) begin
      chk(err == 1'b1, "R3", "err after rejected start", err, 1);
      chk(busy == 1'b0, "R3", "busy after rejected start", busy, 0);
      for (int i = 0; i < 4; i++) begin
        chk(!bus_rd && !bus_wr && !dack, "R3", "no strobe after reject",
            {bus_rd, bus_wr, dack}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(err == 1'b0, "R3", "err cleared by legal start", err, 0);
    chk((bus_rd || bus_wr) && bus_req, "R10", "first strobe after start",
        {bus_req, bus_rd, bus_wr}, 1);
    total = (kind == 1) ? n : 2 * n;
    k = 0; mism = 0; dn = 0; gaps = 0; iter = 0; first = 1; ftxt = "";
    while (iter < 5000) begin
      iter++;
      rdy = ($urandom % 100) >= wait_pct;
      bus_ready = rdy;
      if (done) dn++;
      if (busy && !bus_req) gaps++;
      if ((bus_rd || bus_wr) && rdy) begin
        if (kind == 1) begin
          u = k;
          dk_e = 1;
          rd_e = (de == 0);
          wr_e = (se == 0);
          a_e = (se == 0) ? addr_at(da, dm, sz, u) : addr_at(sa, sm, sz, u);
          w_e = bus_wdata;
        end else begin
          u = k / 2;
          dk_e = 0;
          rd_e = (k % 2 == 0);
          wr_e = !rd_e;
          a_e = rd_e ? addr_at(sa, sm, sz, u) : addr_at(da, dm, sz, u);
          w_e = rd_e ? bus_wdata : rdata_of(addr_at(sa, sm, sz, u));
        end
        if (bus_rd != rd_e || bus_wr != wr_e || dack != dk_e ||
            bus_addr != a_e || bus_wdata != w_e) begin
          if (mism == 0)
            $display("FAIL %s cycle %0d: addr %0h/%0h rd %0b/%0b wr %0b/%0b dack %0b/%0b wdata %0h/%0h",
                     (kind == 1) ? "R4 R6" : "R5 R6", k, bus_addr, a_e, bus_rd, rd_e,
                     bus_wr, wr_e, dack, dk_e, bus_wdata, w_e);
          mism++;
        end
        k++;
      end
      if (!busy && !first) break;
      first = 0;
      @(negedge clk);
    end
    bus_ready = 1'b0;
    chk(mism == 0, (kind == 1) ? "R4" : "R5", "bus cycle contents mismatches", mism, 0);
    chk(k == total, (kind == 1) ? "R1 R4" : "R2 R5", "bus cycle count", k, total);
    chk(dn == 1, "R8", "done pulses", dn, 1);
    chk(gaps == (bst ? 0 : n - 1), "R9", "released-bus cycles", gaps, bst ? 0 : n - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; bus_ready = 1'b0;
    src_ep = 0; dst_ep = 0; xfer_size = 0; periph_size = 0; src_mode = 0; dst_mode = 0;
    burst = 0; src_addr = 0; dst_addr = 0; unit_count = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !bus_req && !bus_rd && !bus_wr && !dack, "R8",
        "reset state", {busy, done, err, bus_req, bus_rd, bus_wr, dack}, 0);

    // R1 single: memory to device, device to memory, burst and steal
    run_xfer(3'd1, 3'd0, 2'd2, 2'd0, 2'd1, 2'd0, 1'b1, 32'h1000, 32'h0, 16'd4, 30);
    run_xfer(3'd0, 3'd2, 2'd1, 2'd0, 2'd0, 2'd2, 1'b0, 32'h0, 32'h2000, 16'd3, 0);
    // R2 dual, R6 mixed modes, R7 heavy waits
    run_xfer(3'd4, 3'd1, 2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 32'h0000_0002, 32'h3000, 16'd5, 70);
    run_xfer(3'd3, 3'd4, 2'd1, 2'd1, 2'd0, 2'd1, 1'b1, 32'h4000, 32'h5000, 16'd3, 0);
    // R9 single unit, no gap
    run_xfer(3'd2, 3'd1, 2'd2, 2'd0, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFC, 32'h10, 16'd1, 10);
    // R1/R2/R3 rejections
    run_xfer(3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0, 0, 16'd2, 0);
    run_xfer(3'd0, 3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0, 0, 16'd2, 0);
    run_xfer(3'd4, 3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0, 0, 16'd2, 0);
    run_xfer(3'd1, 3'd3, 2'd2, 2'd1, 2'd1, 2'd1, 1'b0, 0, 0, 16'd2, 0);
    run_xfer(3'd5, 3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0, 0, 16'd2, 0);
    run_xfer(3'd1, 3'd4, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 0, 0, 16'd0, 0);
    // R3 legal start after a reject clears err
    run_xfer(3'd1, 3'd2, 2'd0, 2'd0, 2'd1, 2'd1, 1'b1, 32'h100, 32'h200, 16'd2, 0);

    for (int t = 0; t < 60; t++) begin
      logic [1:0] sz, psz;
      sz  = 2'($urandom % 3);
      psz = ($urandom % 4 == 0) ? 2'($urandom % 3) : sz;
      run_xfer(3'($urandom % 6), 3'($urandom % 6), sz, psz,
               2'($urandom % 3), 2'($urandom % 3), 1'($urandom % 2),
               $urandom, $urandom, CW'($urandom % 7), $urandom % 60);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule